// File: doc/BRIEF.md
# CDR Frequency Lock Supervisor

This block supervises a clock-and-data-recovery loop from the reference clock domain. A divided copy of the recovered clock arrives as a toggle signal. The block synchronises it, counts its edges over a fixed window of reference cycles, and compares the count with the value expected for the selected reference range. An edge-count error within a set tolerance counts as a good window. Anything else counts as a miss.

A small controller uses the window results to choose the loop input. In the hold state the loop runs from the reference. From there the block lets the loop track the data for a trial window. It declares lock after two good trial windows in a row. A single missed window drops lock and returns the loop to the reference. The retry then starts again.

Two inputs override the controller at once. Loss of signal also forces the incoming data to zero. The active-low force-reference input pins the loop to the reference, and with lock low the output data counts as invalid.

Top module: `cdr_flock_det`

## Requirements
- R1: While `rst` is high and on the cycle after it, `locked`=0, `use_ref`=1 and `force_zero`=0.
- R2: After reset or after an override ends, `use_ref` stays 1 for one window of WIN_LEN reference cycles. It then goes to 0 for a trial window.
- R3: Two good windows in a row with `use_ref`=0 raise `locked` at the end of the second. `locked` never rises straight out of the hold state.
- R4: A missed trial window returns the block to the hold state (`use_ref`=1). Retries keep alternating one hold window with one trial window.
- R5: While locked, one missed window clears `locked` and sets `use_ref`=1 at the end of that window.
- R6: The expected edge count per window is 16*WIN_LEN/DIV_N when `rate_hi`=1 and 128*WIN_LEN/DIV_N when `rate_hi`=0. A window is good when the count is within ±TOL of it, both limits included.
- R7: `sig_det_n`=1 means loss of signal. Within three cycles it gives `force_zero`=1, `use_ref`=1 and `locked`=0, and these hold for as long as the input stays high, whatever the counts.
- R8: `hold_ref_n`=0 gives `use_ref`=1 and `locked`=0 within three cycles, for as long as it is held. It does not set `force_zero`.
- R9: When an override is released, the block starts a new hold window and later reacquires lock through the normal trial sequence.
- R10: A reset pulse while locked clears `locked` and sets `use_ref`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_hi | input | 1 | Reference range: 1 = high (~155.52 MHz), 0 = low (~19.44 MHz) |
| sig_det_n | input | 1 | Signal detect, 0 = signal present, 1 = loss of signal (asynchronous) |
| hold_ref_n | input | 1 | Force loop onto reference, active low (asynchronous) |
| dclk_tog | input | 1 | Toggles once per edge of the divided recovered clock (asynchronous) |
| locked | output | 1 | Lock indication |
| use_ref | output | 1 | 1 = loop input is the reference, 0 = loop tracks data |
| force_zero | output | 1 | 1 = incoming data forced to constant zero |

## Verification
The window verdict and an override can land on the same cycle. The bench provokes this by raising loss of signal or force-reference while the block is locked, and by holding it across several window boundaries. Within three cycles it must see the override state, and it must stay there while good windows keep arriving. After release, it judges the sequence of hold window, trial window and relock by sampling at the middle of each window.

// File: rtl/fld_pkg.sv
package fld_pkg;

    localparam int unsigned RATIO_HI = 16;
    localparam int unsigned RATIO_LO = 128;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_TRY     = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_LOCKED  = 2'd3
    } fld_state_e;

    typedef struct packed {
        logic win_end;
        logic in_tol;
    } win_res_t;

    typedef struct packed {
        logic tog;
        logic los;
        logic hold_n;
    } async_in_t;

    function automatic int unsigned expect_edges(input int unsigned ratio,
                                                 input int unsigned win,
                                                 input int unsigned div);
        return (ratio * win) / div;
    endfunction

endpackage

// File: rtl/fld_sync.sv
module fld_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fld_win_meas.sv
module fld_win_meas
    import fld_pkg::*;
#(
    parameter int unsigned WIN_LEN = 1024,
    parameter int unsigned DIV_N   = 512,
    parameter int unsigned TOL     = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     rate_hi,
    input  logic     tog_s,
    output win_res_t res
);
    localparam int unsigned EXP_HI = expect_edges(RATIO_HI, WIN_LEN, DIV_N);
    localparam int unsigned EXP_LO = expect_edges(RATIO_LO, WIN_LEN, DIV_N);
    localparam int unsigned CNT_W  = $clog2(WIN_LEN + EXP_LO + TOL + 2);
    localparam int unsigned WIN_W  = $clog2(WIN_LEN);

    logic             tog_q;
    logic             edge_seen;
    logic             last;
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] expect_v;
    logic [CNT_W-1:0] diff;

    always_comb begin
        edge_seen   = tog_s ^ tog_q;
        last        = (win_cnt == WIN_W'(WIN_LEN - 1));
        total       = edge_cnt + CNT_W'(edge_seen);
        expect_v    = rate_hi ? CNT_W'(EXP_HI) : CNT_W'(EXP_LO);
        diff        = (total >= expect_v) ? (total - expect_v) : (expect_v - total);
        res.win_end = last & ~clear;
        res.in_tol  = (diff <= CNT_W'(TOL));
    end

    always_ff @(posedge clk) begin
        if (rst) tog_q <= 1'b0;
        else     tog_q <= tog_s;
    end

    always_ff @(posedge clk) begin
        if (rst || clear || last) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else begin
            win_cnt  <= win_cnt + 1'b1;
            edge_cnt <= total;
        end
    end
endmodule

// File: rtl/fld_ctrl.sv
module fld_ctrl
    import fld_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       override,
    input  win_res_t   res,
    output fld_state_e state
);
    fld_state_e nxt;

    always_comb begin
        nxt = state;
        if (override) begin
            nxt = ST_HOLD;
        end else if (res.win_end) begin
            unique case (state)
                ST_HOLD:    nxt = ST_TRY;
                ST_TRY:     nxt = res.in_tol ? ST_CONFIRM : ST_HOLD;
                ST_CONFIRM: nxt = res.in_tol ? ST_LOCKED  : ST_HOLD;
                ST_LOCKED:  nxt = res.in_tol ? ST_LOCKED  : ST_HOLD;
                default:    nxt = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= nxt;
    end
endmodule

// File: rtl/cdr_flock_det.sv
module cdr_flock_det
    import fld_pkg::*;
#(
    parameter int unsigned WIN_LEN = 1024,
    parameter int unsigned DIV_N   = 512,
    parameter int unsigned TOL     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_hi,
    input  logic sig_det_n,
    input  logic hold_ref_n,
    input  logic dclk_tog,
    output logic locked,
    output logic use_ref,
    output logic force_zero
);
    async_in_t  raw_in;
    async_in_t  syn_in;
    logic       override;
    win_res_t   res;
    fld_state_e state;

    assign raw_in = '{tog: dclk_tog, los: sig_det_n, hold_n: hold_ref_n};

    fld_sync #(
        .W      ($bits(async_in_t)),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_in),
        .q  (syn_in)
    );

    assign override = syn_in.los | ~syn_in.hold_n;

    fld_win_meas #(
        .WIN_LEN(WIN_LEN),
        .DIV_N  (DIV_N),
        .TOL    (TOL)
    ) u_meas (
        .clk    (clk),
        .rst    (rst),
        .clear  (override),
        .rate_hi(rate_hi),
        .tog_s  (syn_in.tog),
        .res    (res)
    );

    fld_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .override(override),
        .res     (res),
        .state   (state)
    );

    assign locked     = (state == ST_LOCKED);
    assign use_ref    = (state == ST_HOLD);
    assign force_zero = syn_in.los;
endmodule

// File: rtl/cdr_flock_det_chk.sv
module cdr_flock_det_chk (
    input logic clk,
    input logic rst,
    input logic sig_det_n,
    input logic hold_ref_n,
    input logic locked,
    input logic use_ref,
    input logic force_zero
);
    // R7
    los_forces_ref_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sig_det_n, 3) && !$past(rst, 1) && !$past(rst, 2)) |-> (use_ref && !locked));

    // R7
    los_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sig_det_n, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> force_zero);

    // R8
    force_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(hold_ref_n, 3) && !$past(rst, 1) && !$past(rst, 2)) |-> (use_ref && !locked));

    // R3
    lock_after_trial_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (!$past(use_ref) && !$past(force_zero)));

    // R2
    release_to_trial_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(use_ref) |-> !locked);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!locked && use_ref && !force_zero));
endmodule

bind cdr_flock_det cdr_flock_det_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sig_det_n (sig_det_n),
    .hold_ref_n(hold_ref_n),
    .locked    (locked),
    .use_ref   (use_ref),
    .force_zero(force_zero)
);

// File: tb/cdr_flock_det_bench.sv
module cdr_flock_det_bench;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned WIN = 1024;
    localparam int unsigned DIVN = 512;
    localparam int unsigned TOLC = 2;
    localparam int VEC_N = 9;
    // {rate_hi, toggle period in reference cycles, lock expected}
    localparam logic [17:0] VECS [VEC_N] = '{
        {1'b1, 16'd32, 1'b1},
        {1'b1, 16'd31, 1'b1},
        {1'b1, 16'd34, 1'b1},
        {1'b1, 16'd36, 1'b0},
        {1'b1, 16'd28, 1'b0},
        {1'b1, 16'd4,  1'b0},
        {1'b0, 16'd4,  1'b1},
        {1'b0, 16'd5,  1'b0},
        {1'b0, 16'd32, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_hi = 1'b1;
    logic sig_det_n = 1'b0;
    logic hold_ref_n = 1'b1;
    logic dclk_tog = 1'b0;
    logic locked, use_ref, force_zero;
    int   tog_per = 0;
    int   n_run = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cdr_flock_det #(.WIN_LEN(WIN), .DIV_N(DIVN), .TOL(TOLC)) u_cdr_flock_det (
        .clk(clk), .rst(rst), .rate_hi(rate_hi), .sig_det_n(sig_det_n),
        .hold_ref_n(hold_ref_n), .dclk_tog(dclk_tog),
        .locked(locked), .use_ref(use_ref), .force_zero(force_zero)
    );

    initial begin
        forever begin
            if (tog_per == 0) @(posedge clk);
            else begin
                repeat (tog_per) @(posedge clk);
                #1 dclk_tog = ~dclk_tog;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        wait_cyc(2);
        check("R1 locked", locked, 1'b0);
        check("R1 use_ref", use_ref, 1'b1);
        check("R1 force_zero", force_zero, 1'b0);

        foreach (VECS[i]) begin
            rate_hi = VECS[i][17];
            tog_per = int'(VECS[i][16:1]);
            do_reset();
            wait_cyc(WIN / 2);
            check("R2 hold window", use_ref, 1'b1);
            wait_cyc(WIN);
            check("R2 trial window", use_ref, 1'b0);
            wait_cyc(WIN);
            check("R4 second window use_ref", use_ref, !VECS[i][0]);
            wait_cyc(WIN);
            check("R6 R3 lock verdict", locked, VECS[i][0]);
            check("R4 trial after miss use_ref", use_ref, 1'b0);
        end

        // R5 single miss drops lock
        rate_hi = 1'b1; tog_per = 32;
        do_reset();
        wait_cyc(WIN * 7 / 2);
        check("R5 locked before miss", locked, 1'b1);
        tog_per = 40;
        wait_cyc(2 * WIN);
        check("R5 locked after miss", locked, 1'b0);
        tog_per = 32;
        wait_cyc(4 * WIN);
        check("R4 relock after retry", locked, 1'b1);

        // R7 loss of signal overrides; R9 release
        sig_det_n = 1'b1;
        wait_cyc(4);
        check("R7 force_zero", force_zero, 1'b1);
        check("R7 locked", locked, 1'b0);
        check("R7 use_ref", use_ref, 1'b1);
        wait_cyc(2 * WIN);
        check("R7 held use_ref", use_ref, 1'b1);
        check("R7 held force_zero", force_zero, 1'b1);
        sig_det_n = 1'b0;
        wait_cyc(4);
        check("R9 force_zero cleared", force_zero, 1'b0);
        wait_cyc(WIN / 2);
        check("R9 fresh hold", use_ref, 1'b1);
        wait_cyc(WIN);
        check("R9 trial", use_ref, 1'b0);
        wait_cyc(2 * WIN);
        check("R9 relock", locked, 1'b1);

        // R8 forced reference
        hold_ref_n = 1'b0;
        wait_cyc(4);
        check("R8 use_ref", use_ref, 1'b1);
        check("R8 locked", locked, 1'b0);
        check("R8 no force_zero", force_zero, 1'b0);
        wait_cyc(3 * WIN);
        check("R8 held use_ref", use_ref, 1'b1);
        hold_ref_n = 1'b1;
        wait_cyc(4 + WIN * 7 / 2);
        check("R8 R9 relock", locked, 1'b1);

        // R10 reset while locked
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R10 locked", locked, 1'b0);
        check("R10 use_ref", use_ref, 1'b1);
        rst = 1'b0;
        wait_cyc(4);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule